// File: doc/BRIEF.md
# Byte-Wide Fuse Array Read Sequencer

This block reads bytes out of a one-time-programmable fuse array that is organised by byte. A host hands it a start byte address and a byte count over a request/acknowledge handshake. The block then walks the array's pins through a fixed read protocol. It places the array in read mode and, for every byte, first zeroes the address lines and then drives the address. It raises strobe, samples the returned byte while strobe is high and lowers strobe again. Each step is held for at least one microsecond, measured in clock cycles. After the last byte it returns the array pins to their standby levels and signals completion.

Each byte that is read appears on a data output together with a one-cycle valid pulse. Addresses advance by one and wrap at the top of the 1024-byte space. A small read-only register view reports two things at byte offsets. One is the live pin state, packed into a control word. The other is the most recently captured byte. Programming the fuses is not part of this block.

Top module: `fuse_rd_seq`

## Requirements
- R1: Out of reset the array pins are at standby: active-low chip select high, active-low program enable high, load low, strobe low, address lines zero. busy, ack, done and rd_valid are low.
- R2: A request (req high) seen while idle is accepted on that clock edge, and ack is high for exactly the following cycle with busy high.
- R3: Whenever chip select is low, load and program enable are both high. After acceptance, chip select goes low with strobe low and the address lines zero, and this read-mode state is held for at least CYCLES_PER_US cycles before any address is driven. The first strobe therefore rises no earlier than 2*CYCLES_PER_US+1 cycles after chip select falls.
- R4: Before each strobe, the address lines are zero for at least one cycle. Then the byte address is driven and held for at least CYCLES_PER_US cycles before strobe rises.
- R5: Strobe stays high for at least CYCLES_PER_US cycles, and the address does not change while strobe is high. After it falls, strobe stays low for at least CYCLES_PER_US cycles before the next byte begins.
- R6: Each byte is taken from the array data input in the last strobe-high cycle. It is presented on rd_data with a one-cycle rd_valid pulse in the cycle strobe falls. Bytes come from the start address upward by one, modulo 1024.
- R7: A request for N bytes produces exactly N rd_valid pulses. A request for zero bytes produces none and no strobe, but still enters and leaves read mode.
- R8: When the run ends, done pulses for one cycle. In that cycle busy is low and the pins are at the standby levels of R1.
- R9: req asserted while busy is ignored: no ack, and the address sequence and byte count of the run in progress are unchanged.
- R10: Register view: offset 0x0 reads the control word (bit 0 chip select, bit 1 strobe, bit 2 load, bit 3 program enable, bits [15:6] address lines, other bits zero). Offset 0x4 reads the last captured byte in bits [7:0], zero after reset. Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Read request |
| req_addr | input | 10 | Start byte address |
| req_len | input | LEN_W | Number of bytes to read |
| ack | output | 1 | One-cycle pulse when a request is accepted |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when the run has ended at standby |
| rd_valid | output | 1 | One-cycle pulse with each captured byte |
| rd_data | output | 8 | Captured byte |
| fuse_cs_n | output | 1 | Array chip select, active low |
| fuse_strobe | output | 1 | Array read strobe |
| fuse_load | output | 1 | Array read-mode load |
| fuse_prog_en_n | output | 1 | Array program enable, active low |
| fuse_addr | output | 10 | Array byte address |
| fuse_dout | input | 8 | Byte returned by the array |
| reg_addr | input | REG_AW | Register view byte offset |
| reg_rdata | output | 32 | Register view read data |

## Verification
The hardest situation to reach is a request that arrives while a run is in flight. To produce it, the stimulus holds req high with a different address and length for a stretch of cycles mid-run. The bench then confirms that no ack appears and that the byte stream still follows the original start address and count. The wrap from the top address back to zero also needs deliberate setup, so a directed run starts a few bytes below 1024. A zero-length run is directed as well, and random start addresses and lengths fill in between.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

  localparam int FUSE_AW = 10;
  localparam int FUSE_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTRY,
    ST_CLR,
    ST_SETUP,
    ST_STRB,
    ST_RELS
  } seq_state_t;

  typedef struct packed {
    logic [FUSE_AW-1:0] addr;
    logic               prog_en_n;
    logic               load;
    logic               strobe;
    logic               cs_n;
  } fuse_pins_t;

  // Pin levels belonging to each sequencer state.
  function automatic fuse_pins_t pins_for(seq_state_t s, logic [FUSE_AW-1:0] a);
    fuse_pins_t p;
    p.addr      = '0;
    p.prog_en_n = 1'b1;
    p.load      = 1'b1;
    p.strobe    = 1'b0;
    p.cs_n      = 1'b0;
    case (s)
      ST_IDLE: begin
        p.load = 1'b0;
        p.cs_n = 1'b1;
      end
      ST_SETUP, ST_RELS: p.addr = a;
      ST_STRB: begin
        p.addr   = a;
        p.strobe = 1'b1;
      end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/fuse_step_timer.sv
module fuse_step_timer #(
  parameter int STEP_CYCLES = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);
  localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = start | (cnt_q != '0);
  assign expire = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start)       cnt_d = CW'(STEP_CYCLES - 1);
    else if (cnt_en) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fuse_seq_fsm.sv
module fuse_seq_fsm
  import fuse_rd_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [FUSE_AW-1:0] req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               tmr_expire,
  output logic               tmr_start,
  input  logic [FUSE_DW-1:0] fuse_dout,
  output fuse_pins_t         pins,
  output logic               ack,
  output logic               busy,
  output logic               done,
  output logic               rd_valid,
  output logic [FUSE_DW-1:0] rd_data
);

  seq_state_t         state_q, state_d;
  logic [FUSE_AW-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]   left_q, left_d;
  logic [FUSE_DW-1:0] data_q, data_d;
  fuse_pins_t         pins_q, pins_d;
  logic               ack_q, ack_d, done_q, done_d, valid_q, valid_d;

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    left_d    = left_q;
    data_d    = data_q;
    tmr_start = 1'b0;
    ack_d     = 1'b0;
    done_d    = 1'b0;
    valid_d   = 1'b0;
    case (state_q)
      ST_IDLE: if (req) begin
        ack_d     = 1'b1;
        addr_d    = req_addr;
        left_d    = req_len;
        state_d   = ST_ENTRY;
        tmr_start = 1'b1;
      end
      ST_ENTRY: if (tmr_expire) begin
        if (left_q == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_CLR;
        end
      end
      ST_CLR: begin
        state_d   = ST_SETUP;
        tmr_start = 1'b1;
      end
      ST_SETUP: if (tmr_expire) begin
        state_d   = ST_STRB;
        tmr_start = 1'b1;
      end
      ST_STRB: if (tmr_expire) begin
        data_d    = fuse_dout;
        valid_d   = 1'b1;
        left_d    = left_q - LEN_W'(1);
        state_d   = ST_RELS;
        tmr_start = 1'b1;
      end
      ST_RELS: if (tmr_expire) begin
        if (left_q == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          addr_d  = addr_q + FUSE_AW'(1);
          state_d = ST_CLR;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    pins_d = pins_for(state_d, addr_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      data_q  <= '0;
      pins_q  <= pins_for(ST_IDLE, '0);
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      data_q  <= data_d;
      pins_q  <= pins_d;
      ack_q   <= ack_d;
      done_q  <= done_d;
      valid_q <= valid_d;
    end
  end

  assign pins     = pins_q;
  assign ack      = ack_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign rd_valid = valid_q;
  assign rd_data  = data_q;

  // R2: an acknowledge only follows a request seen while idle
  a_r2_ack_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> $past(req) && !$past(busy));

  // R5: address lines steady for as long as strobe is high
  a_r5_addr_steady_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_q.strobe && $past(pins_q.strobe)) |-> $stable(pins_q.addr));

  // R4: strobe rises only onto an address already driven in read mode
  a_r4_rise_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins_q.strobe) |-> ($stable(pins_q.addr) && pins_q.load && !pins_q.cs_n));

  // R6: a captured byte is reported in the cycle strobe falls
  a_r6_capture_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $fell(pins_q.strobe));

  // R8: completion coincides with standby pins and busy low
  a_r8_done_standby: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (pins_q.cs_n && pins_q.prog_en_n && !pins_q.load &&
                !pins_q.strobe && (pins_q.addr == '0) && !busy));

endmodule

// File: rtl/fuse_reg_view.sv
module fuse_reg_view
  import fuse_rd_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  fuse_pins_t         pins,
  input  logic [FUSE_DW-1:0] last_byte,
  input  logic [REG_AW-1:0]  reg_addr,
  output logic [31:0]        reg_rdata
);
  localparam logic [REG_AW-1:0] OFS_CTRL = REG_AW'(0);
  localparam logic [REG_AW-1:0] OFS_DATA = REG_AW'(4);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_CTRL)
      reg_rdata = {16'b0, pins.addr, 2'b00, pins.prog_en_n, pins.load,
                   pins.strobe, pins.cs_n};
    else if (reg_addr == OFS_DATA)
      reg_rdata = {{(32-FUSE_DW){1'b0}}, last_byte};
  end

endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int CYCLES_PER_US = 125,
  parameter int LEN_W         = 11,
  parameter int REG_AW        = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [FUSE_AW-1:0] req_addr,
  input  logic [LEN_W-1:0]   req_len,
  output logic               ack,
  output logic               busy,
  output logic               done,
  output logic               rd_valid,
  output logic [FUSE_DW-1:0] rd_data,
  output logic               fuse_cs_n,
  output logic               fuse_strobe,
  output logic               fuse_load,
  output logic               fuse_prog_en_n,
  output logic [FUSE_AW-1:0] fuse_addr,
  input  logic [FUSE_DW-1:0] fuse_dout,
  input  logic [REG_AW-1:0]  reg_addr,
  output logic [31:0]        reg_rdata
);

  logic [1:0] rst_sync_q;
  logic       rst_sn;
  logic       tmr_start, tmr_expire;
  fuse_pins_t pins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  fuse_step_timer #(.STEP_CYCLES(CYCLES_PER_US)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sn),
    .start  (tmr_start),
    .expire (tmr_expire)
  );

  fuse_seq_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sn),
    .req        (req),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .tmr_expire (tmr_expire),
    .tmr_start  (tmr_start),
    .fuse_dout  (fuse_dout),
    .pins       (pins),
    .ack        (ack),
    .busy       (busy),
    .done       (done),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  fuse_reg_view #(.REG_AW(REG_AW)) u_regs (
    .pins      (pins),
    .last_byte (rd_data),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
  );

  assign fuse_cs_n      = pins.cs_n;
  assign fuse_strobe    = pins.strobe;
  assign fuse_load      = pins.load;
  assign fuse_prog_en_n = pins.prog_en_n;
  assign fuse_addr      = pins.addr;

endmodule

// File: tb/fuse_rd_seq_bench.sv
module fuse_rd_seq_bench;
  localparam int W     = 125;
  localparam int LEN_W = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic        ack, busy, done, rd_valid;
  logic [7:0]  rd_data;
  logic        fuse_cs_n, fuse_strobe, fuse_load, fuse_prog_en_n;
  logic [9:0]  fuse_addr;
  logic [7:0]  fuse_dout;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] fuse_val(input logic [9:0] a);
    logic [15:0] t;
    t = a * 16'd37 + {6'b0, a} ^ 16'h5a;
    return t[7:0] ^ {a[9:8], 6'b0};
  endfunction

  function automatic logic [31:0] ctrl_word(input logic [9:0] a, input logic pe,
                                            input logic ld, input logic st, input logic cs);
    return {16'b0, a, 2'b00, pe, ld, st, cs};
  endfunction

  // array model: returns the stored byte while read strobe is active
  assign fuse_dout = (!fuse_cs_n && fuse_load && fuse_strobe) ? fuse_val(fuse_addr) : 8'h00;

  fuse_rd_seq #(.CYCLES_PER_US(W), .LEN_W(LEN_W)) u_fuse_rd_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_len(req_len),
    .ack(ack), .busy(busy), .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
    .fuse_cs_n(fuse_cs_n), .fuse_strobe(fuse_strobe), .fuse_load(fuse_load),
    .fuse_prog_en_n(fuse_prog_en_n), .fuse_addr(fuse_addr), .fuse_dout(fuse_dout),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata)
  );

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // pin protocol monitor
  logic [9:0] exp_addr = '0;
  int   got = 0;
  logic [7:0] last_byte = '0;
  logic mon_on = 1'b0;
  logic prev_st = 1'b0, prev_cs = 1'b1;
  logic [9:0] prev_a = '0;
  int   hold = 0, hi_cnt = 0, cs_low = 0, strobes = 0;
  logic saw_clr = 1'b0, moved_hi = 1'b0, mode_bad = 1'b0, first = 1'b1;

  always @(negedge clk) if (mon_on) begin
    if (!fuse_cs_n && !(fuse_load && !fuse_prog_en_n === 1'b0 ? 1'b1 : 1'b0))
      ;
    if (!fuse_cs_n && (!fuse_load || !fuse_prog_en_n)) mode_bad <= 1'b1;
    if (fuse_strobe && prev_st && fuse_addr != prev_a) moved_hi <= 1'b1;
    if (fuse_strobe && !prev_st) begin
      strobes <= strobes + 1;
      chk(hold >= W && fuse_addr == prev_a, "R4 address setup", hold, W);
      chk(saw_clr, "R4 address cleared before byte", saw_clr, 1);
      if (first) chk(cs_low >= 2*W+1, "R3 read-mode entry time", cs_low, 2*W+1);
      else       chk(hi_cnt == 0 && hold >= W, "R5 strobe low gap", hold, W);
      if (reg_addr == 4'h0)
        chk(reg_rdata == ctrl_word(exp_addr, 1'b1, 1'b1, 1'b1, 1'b0), "R10 control word",
            reg_rdata, ctrl_word(exp_addr, 1'b1, 1'b1, 1'b1, 1'b0));
      first   <= 1'b0;
      saw_clr <= 1'b0;
    end else if (!fuse_cs_n && !fuse_strobe && fuse_addr == '0) begin
      saw_clr <= 1'b1;
    end
    if (!fuse_strobe && prev_st) begin
      chk(hi_cnt >= W && !moved_hi, "R5 strobe width/address", hi_cnt, W);
      moved_hi <= 1'b0;
    end
    hi_cnt <= fuse_strobe ? hi_cnt + 1 : 0;
    hold   <= (fuse_addr == prev_a) ? hold + 1 : 1;
    cs_low <= fuse_cs_n ? 0 : cs_low + 1;
    if (rd_valid) begin
      chk(rd_data == fuse_val(exp_addr), "R6 byte value", rd_data, fuse_val(exp_addr));
      last_byte <= rd_data;
      exp_addr  <= exp_addr + 10'd1;
      got       <= got + 1;
    end
    prev_st <= fuse_strobe;
    prev_cs <= fuse_cs_n;
    prev_a  <= fuse_addr;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic run(input logic [9:0] a, input int len, input logic poke);
    int limit;
    int cyc;
    logic saw_ack;
    exp_addr = a;
    got      = 0;
    strobes  = 0;
    first    = 1'b1;
    saw_clr  = 1'b0;
    mode_bad = 1'b0;
    @(negedge clk);
    req = 1'b1; req_addr = a; req_len = LEN_W'(len);
    @(negedge clk);
    chk(ack && busy, "R2 ack after accept", {ack, busy}, 2'b11);
    req = 1'b0;
    @(negedge clk);
    chk(!ack, "R2 ack single cycle", ack, 0);
    if (poke) begin
      // R9: request held during a run must be ignored
      saw_ack = 1'b0;
      repeat (20) begin
        req = 1'b1; req_addr = a + 10'd300; req_len = LEN_W'(len + 5);
        @(negedge clk);
        if (ack) saw_ack = 1'b1;
      end
      req = 1'b0;
      chk(!saw_ack, "R9 no ack while busy", saw_ack, 0);
    end
    limit = (len + 2) * (3*W + 2) * 2 + 100;
    cyc = 0;
    while (!done && cyc < limit) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc < limit, "R8 run completes", cyc, limit);
    chk(!busy && fuse_cs_n && fuse_prog_en_n && !fuse_load && !fuse_strobe && fuse_addr == '0,
        "R8 standby at done", {busy, fuse_cs_n, fuse_prog_en_n, fuse_load, fuse_strobe}, 5'b01100);
    chk(got == len, "R7 byte count", got, len);
    if (poke) chk(exp_addr == 10'(a + len), "R9 sequence unchanged", exp_addr, 10'(a + len));
    if (len == 0) chk(strobes == 0, "R7 no strobe for zero length", strobes, 0);
    chk(!mode_bad, "R3 load/program-enable while selected", mode_bad, 0);
    @(negedge clk);
    chk(!done, "R8 done single cycle", done, 0);
    reg_addr = 4'h4;
    #1;
    chk(reg_rdata == {24'b0, last_byte}, "R10 data register", reg_rdata, {24'b0, last_byte});
    reg_addr = 4'h0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int s;
    s = $urandom(32'h1f2e3d);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(fuse_cs_n && fuse_prog_en_n && !fuse_load && !fuse_strobe && fuse_addr == '0,
        "R1 standby pins", {fuse_cs_n, fuse_prog_en_n, fuse_load, fuse_strobe}, 4'b1100);
    chk(!busy && !ack && !done && !rd_valid, "R1 idle outputs", {busy, ack, done, rd_valid}, 0);
    chk(reg_rdata == 32'h9, "R10 control word at reset", reg_rdata, 32'h9);
    reg_addr = 4'h4; #1;
    chk(reg_rdata == 32'h0, "R10 data register at reset", reg_rdata, 0);
    reg_addr = 4'h8; #1;
    chk(reg_rdata == 32'h0, "R10 unused offset", reg_rdata, 0);
    reg_addr = 4'h0;
    mon_on = 1'b1;

    run(10'd5, 1, 1'b0);
    run(10'd0, 0, 1'b0);       // R7 zero length
    run(10'd1020, 8, 1'b0);    // R6 wrap past top address
    run(10'd100, 4, 1'b1);     // R9 request during run
    for (int i = 0; i < 8; i++) begin
      logic [9:0] ra;
      int rl;
      ra = 10'($urandom);
      rl = 1 + int'($urandom % 10);
      run(ra, rl, 1'($urandom % 2));
    end
    summary();
  end

endmodule